// File: doc/BRIEF.md
# Committed-Stream Taint-Check Generator

This block sits at the commit end of a primary thread. For every instruction the primary thread commits, it decides whether a taint-tracking instruction is needed for a second hardware thread context, the checker. It builds that instruction from a fixed opcode-translation table and the committed register fields. Generated instructions go into an instruction FIFO. The effective address of each generated load or store check goes into a separate address FIFO. The checker context pops both FIFOs.

The block keeps its own copy of the per-register taint bits. It updates that copy as each instruction is accepted and uses it, together with the page-taint bit the TLB supplies with each memory access, to drop instructions that cannot change taint state. A branch whose condition register is tainted produces a check instruction and raises an alert. The primary thread is throttled through a ready signal when either FIFO is full. At a system call, the primary thread is held until the checker has consumed everything pending.

Top module: `tcg_gen`

## Requirements
- R1: After reset, the taint vector is all clean, both FIFOs are empty, `sec_alert` is low and `cm_ready` is high for any non-syscall opcode.
- R2: A generated entry is packed as {check opcode[2:0], rd, rs1, rs2}, with the register fields copied from the committed instruction. The primary opcodes map to check opcodes as follows: ALU 1→4, MOVE 2→1, LOAD 3→2, STORE 4→3, BRANCH 5→7, LOAD-IMM 6→5. NOP 0 and SYSCALL 7 produce nothing.
- R3: ALU (rd = rs1 op rs2) sets taint(rd) to taint(rs1) OR taint(rs2). It generates an entry only when that value differs from the current taint(rd).
- R4: MOVE (rd = rs1) copies taint(rs1) to rd. It generates an entry only when taint(rs1) differs from taint(rd).
- R5: LOAD sets taint(rd) to the page-taint input. It is skipped only when the page is clean and rd is clean. When it generates, it also pushes `cm_addr` to the address FIFO.
- R6: STORE, with rs2 as the data register, leaves the taint vector unchanged. It is skipped only when rs2 is clean and the page is clean. When it generates, it also pushes `cm_addr`.
- R7: BRANCH with a tainted rs1 generates an entry, and `sec_alert` is high during the cycle after acceptance. A BRANCH with a clean rs1 generates nothing and leaves `sec_alert` low.
- R8: LOAD-IMM clears taint(rd). It generates an entry only when rd was tainted.
- R9: NOP and SYSCALL generate nothing. A SYSCALL is accepted only when both FIFOs are empty.
- R10: For non-syscall opcodes, `cm_ready` is low while either FIFO is full. An instruction that is not accepted pushes nothing and leaves the taint vector unchanged.
- R11: Each FIFO delivers its entries in commit order. A pop while the FIFO is empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cm_valid | input | 1 | A committed instruction is presented |
| cm_ready | output | 1 | The block accepts the presented instruction |
| cm_op | input | 3 | Primary opcode class (encoding in R2) |
| cm_rd | input | REG_AW | Destination register |
| cm_rs1 | input | REG_AW | First source register (branch condition) |
| cm_rs2 | input | REG_AW | Second source register (store data) |
| cm_addr | input | ADDR_W | Effective address for load or store |
| cm_page_taint | input | 1 | Taint bit of the accessed page, from the TLB |
| chk_ins_valid | output | 1 | Instruction FIFO is not empty |
| chk_ins_data | output | 3+3*REG_AW | Head entry of the instruction FIFO |
| chk_ins_pop | input | 1 | Checker consumes the instruction head |
| chk_adr_valid | output | 1 | Address FIFO is not empty |
| chk_adr_data | output | ADDR_W | Head entry of the address FIFO |
| chk_adr_pop | input | 1 | Checker consumes the address head |
| taint_vec | output | 2**REG_AW | Current per-register taint bits |
| sec_alert | output | 1 | A tainted branch condition was accepted last cycle |

## Verification
`cm_ready` is combinational on the presented opcode and the FIFO levels. The bench therefore samples it one time unit after driving inputs, in the same cycle. The FIFO heads, valid flags and the taint vector change at the accepting edge, so each of them is compared at the next falling edge. `sec_alert` is registered once and is also compared at that falling edge. The bench model applies pops and pushes at the same point of the same cycle, so every comparison reads state as of exactly one edge.

// File: rtl/tcg_pkg.sv
package tcg_pkg;

  typedef enum logic [2:0] {
    P_NOP  = 3'd0,
    P_ALU  = 3'd1,
    P_MOV  = 3'd2,
    P_LD   = 3'd3,
    P_ST   = 3'd4,
    P_BR   = 3'd5,
    P_LDI  = 3'd6,
    P_SYS  = 3'd7
  } prim_op_e;

  typedef enum logic [2:0] {
    S_NONE = 3'd0,
    S_CPY  = 3'd1,
    S_TLD  = 3'd2,
    S_TST  = 3'd3,
    S_OR   = 3'd4,
    S_CLR  = 3'd5,
    S_CHK  = 3'd7
  } sec_op_e;

  // opcode translation table (R2)
  function automatic sec_op_e xlate_op(prim_op_e op);
    case (op)
      P_ALU:   return S_OR;
      P_MOV:   return S_CPY;
      P_LD:    return S_TLD;
      P_ST:    return S_TST;
      P_BR:    return S_CHK;
      P_LDI:   return S_CLR;
      default: return S_NONE;
    endcase
  endfunction

  // filter: does this instruction need a check entry (R3..R9)
  function automatic logic must_gen(prim_op_e op, logic t_rd, logic t_s1,
                                    logic t_s2, logic pg);
    case (op)
      P_ALU:   return (t_s1 | t_s2) != t_rd;
      P_MOV:   return t_s1 != t_rd;
      P_LD:    return pg | t_rd;
      P_ST:    return pg | t_s2;
      P_BR:    return t_s1;
      P_LDI:   return t_rd;
      default: return 1'b0;
    endcase
  endfunction

  // does the opcode write a destination taint bit
  function automatic logic writes_rd(prim_op_e op);
    return (op == P_ALU) || (op == P_MOV) || (op == P_LD) || (op == P_LDI);
  endfunction

  // value written to taint(rd)
  function automatic logic next_taint(prim_op_e op, logic t_s1, logic t_s2,
                                      logic pg);
    case (op)
      P_ALU:   return t_s1 | t_s2;
      P_MOV:   return t_s1;
      P_LD:    return pg;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic needs_addr(prim_op_e op);
    return (op == P_LD) || (op == P_ST);
  endfunction

endpackage

// File: rtl/tcg_fifo.sv
module tcg_fifo #(
  parameter int WIDTH = 18,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] rdata,
  output logic             empty,
  output logic             full
);
  localparam int PW = $clog2(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW:0]      wp;
  logic [PW:0]      rp;
  logic             do_wr;
  logic             do_rd;

  assign empty = (wp == rp);
  assign full  = (wp[PW] != rp[PW]) && (wp[PW-1:0] == rp[PW-1:0]);
  assign rdata = mem[rp[PW-1:0]];
  assign do_wr = push && !full;
  assign do_rd = pop && !empty;

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp[PW-1:0]] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (do_wr) wp <= wp + 1'b1;
      if (do_rd) rp <= rp + 1'b1;
    end
  end
endmodule

// File: rtl/tcg_taint_file.sv
module tcg_taint_file #(
  parameter int REG_AW = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [REG_AW-1:0]        waddr,
  input  logic                     wval,
  input  logic [REG_AW-1:0]        ra_d,
  input  logic [REG_AW-1:0]        ra_1,
  input  logic [REG_AW-1:0]        ra_2,
  output logic                     t_d,
  output logic                     t_1,
  output logic                     t_2,
  output logic [(1<<REG_AW)-1:0]   vec
);
  localparam int NREG = 1 << REG_AW;

  logic [NREG-1:0] bits;
  logic [NREG-1:0] wsel;

  for (genvar i = 0; i < NREG; i++) begin : g_sel
    assign wsel[i] = we && (waddr == REG_AW'(i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bits <= '0;
    else        bits <= (bits & ~wsel) | (wval ? wsel : '0);
  end

  assign t_d = bits[ra_d];
  assign t_1 = bits[ra_1];
  assign t_2 = bits[ra_2];
  assign vec = bits;
endmodule

// File: rtl/tcg_xlate.sv
module tcg_xlate
  import tcg_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic [2:0]            op_raw,
  input  logic [REG_AW-1:0]     rd,
  input  logic [REG_AW-1:0]     rs1,
  input  logic [REG_AW-1:0]     rs2,
  input  logic                  t_rd,
  input  logic                  t_s1,
  input  logic                  t_s2,
  input  logic                  pg,
  output logic                  gen,
  output logic                  addr_need,
  output logic                  wr_rd,
  output logic                  wr_val,
  output logic                  is_sys,
  output logic                  is_alert,
  output logic [3+3*REG_AW-1:0] entry
);
  prim_op_e op;
  sec_op_e  sop;

  assign op        = prim_op_e'(op_raw);
  assign sop       = xlate_op(op);
  assign gen       = must_gen(op, t_rd, t_s1, t_s2, pg);
  assign addr_need = needs_addr(op);
  assign wr_rd     = writes_rd(op);
  assign wr_val    = next_taint(op, t_s1, t_s2, pg);
  assign is_sys    = (op == P_SYS);
  assign is_alert  = (op == P_BR) && t_s1;
  assign entry     = {sop, rd, rs1, rs2};
endmodule

// File: rtl/tcg_gen.sv
module tcg_gen #(
  parameter int REG_AW    = 5,
  parameter int ADDR_W    = 16,
  parameter int INS_DEPTH = 8,
  parameter int ADR_DEPTH = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cm_valid,
  output logic                        cm_ready,
  input  logic [2:0]                  cm_op,
  input  logic [REG_AW-1:0]           cm_rd,
  input  logic [REG_AW-1:0]           cm_rs1,
  input  logic [REG_AW-1:0]           cm_rs2,
  input  logic [ADDR_W-1:0]           cm_addr,
  input  logic                        cm_page_taint,
  output logic                        chk_ins_valid,
  output logic [3+3*REG_AW-1:0]       chk_ins_data,
  input  logic                        chk_ins_pop,
  output logic                        chk_adr_valid,
  output logic [ADDR_W-1:0]           chk_adr_data,
  input  logic                        chk_adr_pop,
  output logic [(1<<REG_AW)-1:0]      taint_vec,
  output logic                        sec_alert
);
  localparam int ENT_W = 3 + 3 * REG_AW;

  logic             t_rd, t_s1, t_s2;
  logic             gen, addr_need, wr_rd, wr_val, is_sys, is_alert;
  logic [ENT_W-1:0] entry;
  logic             ins_empty, ins_full, adr_empty, adr_full;
  logic             accept, ins_push, adr_push, tf_we;

  tcg_taint_file #(.REG_AW(REG_AW)) u_tf (
    .clk(clk), .rst_n(rst_n), .we(tf_we), .waddr(cm_rd), .wval(wr_val),
    .ra_d(cm_rd), .ra_1(cm_rs1), .ra_2(cm_rs2),
    .t_d(t_rd), .t_1(t_s1), .t_2(t_s2), .vec(taint_vec)
  );

  tcg_xlate #(.REG_AW(REG_AW)) u_xl (
    .op_raw(cm_op), .rd(cm_rd), .rs1(cm_rs1), .rs2(cm_rs2),
    .t_rd(t_rd), .t_s1(t_s1), .t_s2(t_s2), .pg(cm_page_taint),
    .gen(gen), .addr_need(addr_need), .wr_rd(wr_rd), .wr_val(wr_val),
    .is_sys(is_sys), .is_alert(is_alert), .entry(entry)
  );

  // syscall waits for a fully drained checker queue; others need space
  assign cm_ready = is_sys ? (ins_empty && adr_empty) : (!ins_full && !adr_full);
  assign accept   = cm_valid && cm_ready;
  assign ins_push = accept && gen;
  assign adr_push = accept && gen && addr_need;
  assign tf_we    = accept && wr_rd;

  tcg_fifo #(.WIDTH(ENT_W), .DEPTH(INS_DEPTH)) u_ins_q (
    .clk(clk), .rst_n(rst_n), .push(ins_push), .wdata(entry),
    .pop(chk_ins_pop), .rdata(chk_ins_data), .empty(ins_empty), .full(ins_full)
  );

  tcg_fifo #(.WIDTH(ADDR_W), .DEPTH(ADR_DEPTH)) u_adr_q (
    .clk(clk), .rst_n(rst_n), .push(adr_push), .wdata(cm_addr),
    .pop(chk_adr_pop), .rdata(chk_adr_data), .empty(adr_empty), .full(adr_full)
  );

  assign chk_ins_valid = !ins_empty;
  assign chk_adr_valid = !adr_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sec_alert <= 1'b0;
    else        sec_alert <= accept && is_alert;
  end
endmodule

// File: rtl/tcg_gen_chk.sv
module tcg_gen_chk #(
  parameter int REG_AW = 5
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   cm_valid,
  input logic                   cm_ready,
  input logic [2:0]             cm_op,
  input logic [REG_AW-1:0]      cm_rd,
  input logic [REG_AW-1:0]      cm_rs1,
  input logic [(1<<REG_AW)-1:0] taint_vec,
  input logic                   sec_alert,
  input logic                   chk_ins_valid,
  input logic                   chk_adr_valid,
  input logic                   ins_push,
  input logic                   adr_push,
  input logic                   ins_full,
  input logic                   adr_full
);
  a_r10_ins_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    ins_push |-> !ins_full);

  a_r10_adr_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    adr_push |-> !adr_full);

  a_r10_stall_keeps_taint: assert property (@(posedge clk) disable iff (!rst_n)
    (cm_valid && !cm_ready) |=> $stable(taint_vec));

  a_r5_addr_with_entry: assert property (@(posedge clk) disable iff (!rst_n)
    adr_push |-> ins_push);

  a_r9_sys_drained: assert property (@(posedge clk) disable iff (!rst_n)
    (cm_valid && cm_ready && cm_op == 3'd7) |-> (!chk_ins_valid && !chk_adr_valid));

  a_r8_ldi_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (cm_valid && cm_ready && cm_op == 3'd6) |=> !taint_vec[$past(cm_rd)]);

  a_r7_alert_source: assert property (@(posedge clk) disable iff (!rst_n)
    sec_alert |-> $past(cm_valid && cm_ready && cm_op == 3'd5 && taint_vec[cm_rs1]));
endmodule

bind tcg_gen tcg_gen_chk #(.REG_AW(REG_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cm_valid(cm_valid), .cm_ready(cm_ready),
  .cm_op(cm_op), .cm_rd(cm_rd), .cm_rs1(cm_rs1), .taint_vec(taint_vec),
  .sec_alert(sec_alert), .chk_ins_valid(chk_ins_valid),
  .chk_adr_valid(chk_adr_valid), .ins_push(ins_push), .adr_push(adr_push),
  .ins_full(ins_full), .adr_full(adr_full)
);

// File: tb/tcg_gen_test.sv
`timescale 1ns/1ps
module tcg_gen_test;
  localparam int RA = 5;
  localparam int AWD = 16;
  localparam int DEP = 8;
  localparam int EW = 3 + 3 * RA;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cm_valid = 1'b0;
  logic cm_ready;
  logic [2:0] cm_op = '0;
  logic [RA-1:0] cm_rd = '0, cm_rs1 = '0, cm_rs2 = '0;
  logic [AWD-1:0] cm_addr = '0;
  logic cm_page_taint = 1'b0;
  logic chk_ins_valid, chk_adr_valid, sec_alert;
  logic [EW-1:0] chk_ins_data;
  logic [AWD-1:0] chk_adr_data;
  logic chk_ins_pop = 1'b0, chk_adr_pop = 1'b0;
  logic [31:0] taint_vec;

  always #4 clk = ~clk;

  tcg_gen #(.REG_AW(RA), .ADDR_W(AWD), .INS_DEPTH(DEP), .ADR_DEPTH(DEP)) uut (
    .clk(clk), .rst_n(rst_n), .cm_valid(cm_valid), .cm_ready(cm_ready),
    .cm_op(cm_op), .cm_rd(cm_rd), .cm_rs1(cm_rs1), .cm_rs2(cm_rs2),
    .cm_addr(cm_addr), .cm_page_taint(cm_page_taint),
    .chk_ins_valid(chk_ins_valid), .chk_ins_data(chk_ins_data),
    .chk_ins_pop(chk_ins_pop), .chk_adr_valid(chk_adr_valid),
    .chk_adr_data(chk_adr_data), .chk_adr_pop(chk_adr_pop),
    .taint_vec(taint_vec), .sec_alert(sec_alert)
  );

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [31:0] mtv = '0;
  logic [EW-1:0] qi[$];
  logic [AWD-1:0] qa[$];
  logic exp_alert = 1'b0;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  // check-op code for each primary class, as listed in R2
  function automatic logic [2:0] m_code(input logic [2:0] op);
    logic [2:0] tbl [8];
    tbl = '{3'd0, 3'd4, 3'd1, 3'd2, 3'd3, 3'd7, 3'd5, 3'd0};
    return tbl[op];
  endfunction

  function automatic logic m_gen(input logic [2:0] op, input logic trd,
                                 input logic t1, input logic t2, input logic pg);
    logic nv;
    case (op)
      3'd1: begin nv = t1 | t2; return nv ^ trd; end
      3'd2: return t1 ^ trd;
      3'd3: return !(!pg && !trd);
      3'd4: return !(!pg && !t2);
      3'd5: return t1;
      3'd6: return trd;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check_outs(input string tag);
    check({tag, " ins_valid R11"}, 64'(chk_ins_valid), 64'(qi.size() > 0));
    if (qi.size() > 0) check({tag, " ins_data R2"}, 64'(chk_ins_data), 64'(qi[0]));
    check({tag, " adr_valid R11"}, 64'(chk_adr_valid), 64'(qa.size() > 0));
    if (qa.size() > 0) check({tag, " adr_data R5"}, 64'(chk_adr_data), 64'(qa[0]));
    check({tag, " taint_vec"}, 64'(taint_vec), 64'(mtv));
    check({tag, " sec_alert R7"}, 64'(sec_alert), 64'(exp_alert));
  endtask

  task automatic step(input logic v, input logic [2:0] op, input logic [RA-1:0] rd,
                      input logic [RA-1:0] s1, input logic [RA-1:0] s2,
                      input logic [AWD-1:0] ad, input logic pg,
                      input logic ip, input logic ap, input string tag);
    logic erdy, acc, g, trd, t1, t2;
    cm_valid = v; cm_op = op; cm_rd = rd; cm_rs1 = s1; cm_rs2 = s2;
    cm_addr = ad; cm_page_taint = pg; chk_ins_pop = ip; chk_adr_pop = ap;
    #1;
    if (op == 3'd7) erdy = (qi.size() == 0) && (qa.size() == 0);
    else            erdy = (qi.size() < DEP) && (qa.size() < DEP);
    check({tag, " cm_ready R10"}, 64'(cm_ready), 64'(erdy));
    acc = v && erdy;
    trd = mtv[rd]; t1 = mtv[s1]; t2 = mtv[s2];
    if (ip && qi.size() > 0) void'(qi.pop_front());
    if (ap && qa.size() > 0) void'(qa.pop_front());
    exp_alert = acc && (op == 3'd5) && t1;
    g = m_gen(op, trd, t1, t2, pg);
    if (acc && g) begin
      qi.push_back({m_code(op), rd, s1, s2});
      if (op == 3'd3 || op == 3'd4) qa.push_back(ad);
    end
    if (acc) begin
      case (op)
        3'd1: mtv[rd] = t1 | t2;
        3'd2: mtv[rd] = t1;
        3'd3: mtv[rd] = pg;
        3'd6: mtv[rd] = 1'b0;
        default: ;
      endcase
    end
    @(negedge clk);
    check_outs(tag);
  endtask

  task automatic drain();
    for (int k = 0; k < 2 * DEP + 2; k++) step(1'b0, 3'd0, 0, 0, 0, 0, 1'b0, 1'b1, 1'b1, "R11");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4211));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    #1;
    check("R1 ready", 64'(cm_ready), 64'd1);
    check("R1 ins_valid", 64'(chk_ins_valid), 64'd0);
    check("R1 adr_valid", 64'(chk_adr_valid), 64'd0);
    check("R1 taint_vec", 64'(taint_vec), 64'd0);
    check("R1 sec_alert", 64'(sec_alert), 64'd0);
    @(negedge clk);

    // R5 load from tainted page, then clean load skipped
    step(1, 3'd3, 1, 9, 0, 16'hA001, 1, 0, 0, "R5 tainted load");
    step(1, 3'd3, 2, 9, 0, 16'hA002, 0, 0, 0, "R5 clean load skip");
    drain();
    // R6 stores
    step(1, 3'd4, 0, 9, 3, 16'hB003, 0, 0, 0, "R6 clean store skip");
    step(1, 3'd4, 0, 9, 1, 16'hB004, 0, 0, 0, "R6 tainted data store");
    step(1, 3'd4, 0, 9, 3, 16'hB005, 1, 0, 0, "R6 tainted page store");
    drain();
    // R3 ALU propagate, then no-change skip; R2 entry fields
    step(1, 3'd1, 4, 1, 2, 0, 0, 0, 0, "R3 alu or R2");
    step(1, 3'd1, 4, 1, 0, 0, 0, 0, 0, "R3 alu no change");
    // R4 moves
    step(1, 3'd2, 5, 2, 0, 0, 0, 0, 0, "R4 clean move skip");
    step(1, 3'd2, 5, 4, 0, 0, 0, 0, 0, "R4 tainted move");
    // R7 branches
    step(1, 3'd5, 0, 5, 0, 0, 0, 0, 0, "R7 tainted branch");
    step(1, 3'd5, 0, 2, 0, 0, 0, 0, 0, "R7 clean branch");
    // R8 load-immediate
    step(1, 3'd6, 6, 0, 0, 0, 0, 0, 0, "R8 clean ldi skip");
    step(1, 3'd6, 5, 0, 0, 0, 0, 0, 0, "R8 tainted ldi");
    // R9 nop
    step(1, 3'd0, 1, 1, 1, 0, 1, 0, 0, "R9 nop");
    drain();
    // R10 fill the instruction FIFO, then a stalled instruction
    for (int k = 0; k < DEP; k++) begin
      if (k % 2 == 0) step(1, 3'd6, 4, 0, 0, 0, 0, 0, 0, "R10 fill");
      else            step(1, 3'd2, 4, 1, 0, 0, 0, 0, 0, "R10 fill");
    end
    step(1, 3'd6, 1, 0, 0, 0, 0, 0, 0, "R10 stalled ldi");
    check("R10 stalled ldi kept taint", 64'(taint_vec[1]), 64'd1);
    // R9 syscall waits for drain
    step(1, 3'd7, 0, 0, 0, 0, 0, 0, 0, "R9 sys blocked");
    for (int k = 0; k < DEP + 1; k++) step(1, 3'd7, 0, 0, 0, 0, 0, 1, 1, "R9 sys drain");
    // R11 pops on empty are ignored
    step(0, 3'd0, 0, 0, 0, 0, 0, 1, 1, "R11 empty pop");

    // constrained random
    for (int k = 0; k < 600; k++) begin
      step(1'($urandom_range(0, 3) != 0), 3'($urandom_range(0, 7)),
           RA'($urandom_range(0, 7)), RA'($urandom_range(0, 7)),
           RA'($urandom_range(0, 7)), AWD'($urandom),
           1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
           1'($urandom_range(0, 1)), "R11 random");
    end
    drain();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule